// File: doc/BRIEF.md
# Operand Address Generation Unit

This block works out the effective memory address of a load operand. A requester presents a mode code, an immediate or offset, the values of a base register and an index register, and the number of the base register. The unit answers with the effective address and a one-cycle valid pulse. It does not hold the register file, decode instructions or perform the data load. Register values come in on ports, and any register update leaves on ports.

Most modes finish one cycle after the request. The memory-indirect mode is different. It reads a pointer from memory through a simple read port: one request pulse goes out, and a read-valid response comes back. The result is ready one cycle after that response, and the unit reports busy until then. The post-increment and post-decrement modes return the unmodified base register as the address. In the same cycle they emit a write-back of the base register, stepped by the 4-byte access size.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, `ea_valid`, `wb_valid`, `busy` and `mem_rd_req` are all low.
- R2: Mode code 0 (absolute): one cycle after an accepted request, `ea_valid` is high and `ea_addr` equals `req_imm`.
- R3: Mode code 1 (register indirect): one cycle after an accepted request, `ea_addr` equals `req_base`.
- R4: Mode code 2 (displaced): one cycle after an accepted request, `ea_addr` equals `req_imm + req_base`, modulo 2^AW.
- R5: Mode code 3 (indexed): one cycle after an accepted request, `ea_addr` equals `req_base + req_index`, modulo 2^AW.
- R6: Mode code 4 (memory indirect): one cycle after the request, the unit drives a single-cycle `mem_rd_req` with `mem_rd_addr` equal to `req_base`, and `busy` goes high. One cycle after `mem_rd_valid`, the unit asserts `ea_valid` with `ea_addr` equal to the returned `mem_rd_data`, and `busy` falls.
- R7: While `busy` is high, `req_valid` is ignored. No further read request and no `ea_valid` result from it.
- R8: Mode code 5 (post-increment): `ea_addr` equals `req_base`. In the same cycle, `wb_valid` is high, `wb_reg` equals `req_breg`, and `wb_data` equals `req_base + 4` modulo 2^AW.
- R9: Mode code 6 (post-decrement): `ea_addr` equals `req_base`, and `wb_valid` is high with `wb_data` equal to `req_base - 4` modulo 2^AW.
- R10: `wb_valid` is high only together with `ea_valid` in modes 5 and 6. It stays low in every other mode, including the indirect result.
- R11: `ea_valid` is a one-cycle pulse for each accepted request. When no fetch is outstanding, a `mem_rd_valid` produces no output.
- R12: Mode code 7 is reserved. A request carrying it produces no `ea_valid`, no `wb_valid` and no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_imm | input | AW | Immediate address or offset |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_breg | input | RW | Base register number |
| mem_rd_req | output | 1 | Pointer read request pulse |
| mem_rd_addr | output | AW | Pointer read address |
| mem_rd_valid | input | 1 | Pointer read response strobe |
| mem_rd_data | input | AW | Pointer read response word |
| busy | output | 1 | Indirect fetch outstanding |
| ea_valid | output | 1 | Effective address valid pulse |
| ea_addr | output | AW | Effective address |
| wb_valid | output | 1 | Base register write-back strobe |
| wb_reg | output | RW | Write-back register number |
| wb_data | output | AW | Write-back register value |

## Verification
Only one internal state can go wrong here: the outstanding-fetch flag. If it is stuck high, `busy` stays asserted and the next request gets no `ea_valid` one cycle later. If it is lost, the indirect response is dropped or a second request launches an extra `mem_rd_req` the cycle after it arrives. A wrong stored pointer or write-back value shows in the same cycle as the valid pulse that carries it. The bench therefore checks every response on the exact cycle the valid appears. It also probes the cycle just after each response, and the cycles of a fetch wait.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [2:0] {
        MODE_ABS  = 3'd0,
        MODE_REG  = 3'd1,
        MODE_DISP = 3'd2,
        MODE_IDX  = 3'd3,
        MODE_MIND = 3'd4,
        MODE_AINC = 3'd5,
        MODE_ADEC = 3'd6,
        MODE_RSVD = 3'd7
    } am_mode_e;

    localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/opaddr_ea_sel.sv
// Single-cycle address forming for every mode that needs no memory fetch.
module opaddr_ea_sel
    import opaddr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  am_mode_e          mode,
    input  logic [AW-1:0]     imm,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     index,
    output logic [AW-1:0]     ea,
    output logic              direct
);

    logic [AW-1:0] addend_a;
    logic [AW-1:0] addend_b;

    // One shared adder; each mode selects what feeds it.
    always_comb begin
        addend_a = base;
        addend_b = '0;
        direct   = 1'b1;
        unique case (mode)
            MODE_ABS:  begin addend_a = imm;  addend_b = '0;    end
            MODE_REG:  begin addend_a = base; addend_b = '0;    end
            MODE_DISP: begin addend_a = base; addend_b = imm;   end
            MODE_IDX:  begin addend_a = base; addend_b = index; end
            MODE_AINC,
            MODE_ADEC: begin addend_a = base; addend_b = '0;    end
            default:   begin direct = 1'b0;                     end
        endcase
    end

    assign ea = addend_a + addend_b;

endmodule

// File: rtl/opaddr_wb_gen.sv
// Base register side effect for the post-step modes.
module opaddr_wb_gen
    import opaddr_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 4
) (
    input  am_mode_e          mode,
    input  logic [AW-1:0]     base,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_comb begin
        wb_en  = 1'b0;
        wb_val = base;
        if (mode == MODE_AINC) begin
            wb_en  = 1'b1;
            wb_val = base + STEP_V;
        end else if (mode == MODE_ADEC) begin
            wb_en  = 1'b1;
            wb_val = base - STEP_V;
        end
    end

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned RW   = 5,
    parameter int unsigned STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [AW-1:0]     req_imm,
    input  logic [AW-1:0]     req_base,
    input  logic [AW-1:0]     req_index,
    input  logic [RW-1:0]     req_breg,
    output logic              mem_rd_req,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [AW-1:0]     mem_rd_data,
    output logic              busy,
    output logic              ea_valid,
    output logic [AW-1:0]     ea_addr,
    output logic              wb_valid,
    output logic [RW-1:0]     wb_reg,
    output logic [AW-1:0]     wb_data
);

    typedef struct packed {
        logic          busy;
        logic          rd_req;
        logic [AW-1:0] rd_addr;
        logic          ea_vld;
        logic [AW-1:0] ea;
        logic          wb_vld;
        logic [RW-1:0] wb_reg;
        logic [AW-1:0] wb_val;
    } state_t;

    state_t st_d, st_q;

    am_mode_e      mode_c;
    logic [AW-1:0] ea_c;
    logic          direct_c;
    logic          wb_en_c;
    logic [AW-1:0] wb_val_c;

    assign mode_c = am_mode_e'(req_mode);

    opaddr_ea_sel #(.AW(AW)) u_ea_sel (
        .mode   (mode_c),
        .imm    (req_imm),
        .base   (req_base),
        .index  (req_index),
        .ea     (ea_c),
        .direct (direct_c)
    );

    opaddr_wb_gen #(.AW(AW), .STEP(STEP)) u_wb_gen (
        .mode   (mode_c),
        .base   (req_base),
        .wb_en  (wb_en_c),
        .wb_val (wb_val_c)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rd_req = 1'b0;
        st_d.ea_vld = 1'b0;
        st_d.wb_vld = 1'b0;
        if (st_q.busy) begin
            // Waiting for the pointer word; new requests are dropped.
            if (mem_rd_valid) begin
                st_d.busy   = 1'b0;
                st_d.ea_vld = 1'b1;
                st_d.ea     = mem_rd_data;
            end
        end else if (req_valid) begin
            if (mode_c == MODE_MIND) begin
                st_d.busy    = 1'b1;
                st_d.rd_req  = 1'b1;
                st_d.rd_addr = req_base;
            end else if (direct_c) begin
                st_d.ea_vld = 1'b1;
                st_d.ea     = ea_c;
                st_d.wb_vld = wb_en_c;
                st_d.wb_reg = req_breg;
                st_d.wb_val = wb_val_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rd_req  = st_q.rd_req;
    assign mem_rd_addr = st_q.rd_addr;
    assign busy        = st_q.busy;
    assign ea_valid    = st_q.ea_vld;
    assign ea_addr     = st_q.ea;
    assign wb_valid    = st_q.wb_vld;
    assign wb_reg      = st_q.wb_reg;
    assign wb_data     = st_q.wb_val;

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
    parameter int unsigned AW   = 32,
    parameter int unsigned RW   = 5,
    parameter int unsigned STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_mode,
    input logic [AW-1:0] req_base,
    input logic          mem_rd_req,
    input logic [AW-1:0] mem_rd_addr,
    input logic          mem_rd_valid,
    input logic [AW-1:0] mem_rd_data,
    input logic          busy,
    input logic          ea_valid,
    input logic [AW-1:0] ea_addr,
    input logic          wb_valid,
    input logic [RW-1:0] wb_reg,
    input logic [AW-1:0] wb_data
);

    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic take;
    assign take = req_valid && !busy;

    // R2: one-cycle modes answer on the next cycle
    p_direct_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && (req_mode <= 3'd3 || req_mode == 3'd5 || req_mode == 3'd6) |=> ea_valid);

    // R6: indirect mode launches a read of the base value
    p_rd_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 3'd4 |=> mem_rd_req && busy && !ea_valid
            && mem_rd_addr == $past(req_base));

    // R6: response becomes the address one cycle later
    p_rd_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_rd_valid |=> ea_valid && !busy && !wb_valid
            && ea_addr == $past(mem_rd_data));

    // R7: no second read while a fetch is outstanding
    p_busy_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !mem_rd_req);

    // R8: post-increment write-back value
    p_inc_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 3'd5 |=> wb_valid && ea_addr == $past(req_base)
            && wb_data == $past(req_base) + STEP_V);

    // R9: post-decrement write-back value
    p_dec_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 3'd6 |=> wb_valid && wb_data == $past(req_base) - STEP_V);

    // R10: write-back only alongside an address
    p_wb_with_ea_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ea_valid);

    // R11: valid is a single-cycle pulse
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid && !req_valid |=> !ea_valid);

    // R12: reserved code has no effect
    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take && req_mode == 3'd7 |=> !ea_valid && !mem_rd_req && !busy);

endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW), .RW(RW), .STEP(STEP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_base     (req_base),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .busy         (busy),
    .ea_valid     (ea_valid),
    .ea_addr      (ea_addr),
    .wb_valid     (wb_valid),
    .wb_reg       (wb_reg),
    .wb_data      (wb_data)
);

// File: tb/opaddr_gen_bench.sv
`timescale 1ns/1ps
module opaddr_gen_bench;

    localparam int AW = 32;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_mode = '0;
    logic [AW-1:0] req_imm = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_index = '0;
    logic [RW-1:0] req_breg = '0;
    logic          mem_rd_req;
    logic [AW-1:0] mem_rd_addr;
    logic          mem_rd_valid = 1'b0;
    logic [AW-1:0] mem_rd_data = '0;
    logic          busy;
    logic          ea_valid;
    logic [AW-1:0] ea_addr;
    logic          wb_valid;
    logic [RW-1:0] wb_reg;
    logic [AW-1:0] wb_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    opaddr_gen u_opaddr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_imm(req_imm), .req_base(req_base), .req_index(req_index),
        .req_breg(req_breg), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .wb_valid(wb_valid),
        .wb_reg(wb_reg), .wb_data(wb_data)
    );

    function automatic logic [31:0] exp_ea(input logic [2:0] m, input logic [31:0] imm,
                                           input logic [31:0] b, input logic [31:0] x);
        case (m)
            3'd0:    return imm;
            3'd2:    return imm + b;
            3'd3:    return b + x;
            default: return b;
        endcase
    endfunction

    function automatic logic [31:0] exp_wb(input logic [2:0] m, input logic [31:0] b);
        return (m == 3'd5) ? b + 32'd4 : b - 32'd4;
    endfunction

    function automatic logic [31:0] ptr_of(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_0F96;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R12";
        endcase
    endfunction

    // One-cycle modes (and the reserved code)
    task automatic do_direct(input logic [2:0] m, input logic [31:0] imm,
                             input logic [31:0] b, input logic [31:0] x,
                             input logic [4:0] r);
        string t;
        t = tag_of(m);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_imm = imm;
        req_base = b; req_index = x; req_breg = r;
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 3'd7) begin
            check("R12", "ea_valid", {31'b0, ea_valid}, 32'd0);
            check("R12", "wb_valid", {31'b0, wb_valid}, 32'd0);
            check("R12", "mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
            check("R12", "busy", {31'b0, busy}, 32'd0);
        end else begin
            check(t, "ea_valid", {31'b0, ea_valid}, 32'd1);
            check(t, "ea_addr", ea_addr, exp_ea(m, imm, b, x));
            if (m == 3'd5 || m == 3'd6) begin
                check(t, "wb_valid", {31'b0, wb_valid}, 32'd1);
                check(t, "wb_reg", {27'b0, wb_reg}, {27'b0, r});
                check(t, "wb_data", wb_data, exp_wb(m, b));
            end else begin
                check("R10", "wb_valid", {31'b0, wb_valid}, 32'd0);
            end
        end
        @(negedge clk);
        check("R11", "ea_valid pulse end", {31'b0, ea_valid}, 32'd0);
    endtask

    // Memory-indirect with a given response delay; optionally a request while busy
    task automatic do_ind(input logic [31:0] b, input int lat, input bit poke);
        logic [31:0] p;
        p = ptr_of(b);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd4; req_base = b;
        req_imm = 32'h1111_2222; req_index = 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6", "mem_rd_req", {31'b0, mem_rd_req}, 32'd1);
        check("R6", "mem_rd_addr", mem_rd_addr, b);
        check("R6", "busy", {31'b0, busy}, 32'd1);
        check("R6", "ea_valid early", {31'b0, ea_valid}, 32'd0);
        for (int i = 0; i < lat; i++) begin
            if (poke && i == 0) begin
                req_valid = 1'b1; req_mode = 3'd0; req_imm = 32'hDEAD_0000;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check("R7", "mem_rd_req while busy", {31'b0, mem_rd_req}, 32'd0);
            check("R7", "ea_valid while busy", {31'b0, ea_valid}, 32'd0);
            check("R7", "busy held", {31'b0, busy}, 32'd1);
        end
        mem_rd_valid = 1'b1; mem_rd_data = p;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R6", "ea_valid", {31'b0, ea_valid}, 32'd1);
        check("R6", "ea_addr", ea_addr, p);
        check("R6", "busy clear", {31'b0, busy}, 32'd0);
        check("R10", "wb_valid indirect", {31'b0, wb_valid}, 32'd0);
        @(negedge clk);
        check("R11", "ea_valid pulse end", {31'b0, ea_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4471));
        repeat (3) @(negedge clk);
        check("R1", "ea_valid", {31'b0, ea_valid}, 32'd0);
        check("R1", "wb_valid", {31'b0, wb_valid}, 32'd0);
        check("R1", "busy", {31'b0, busy}, 32'd0);
        check("R1", "mem_rd_req", {31'b0, mem_rd_req}, 32'd0);
        rst_n = 1'b1;

        // Directed corners
        do_direct(3'd0, 32'h0000_1000, 32'h5, 32'h6, 5'd1);
        do_direct(3'd1, 32'h0, 32'hCAFE_0010, 32'h6, 5'd2);
        do_direct(3'd2, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0, 5'd3);
        do_direct(3'd3, 32'h0, 32'h8000_0000, 32'h8000_0004, 5'd4);
        do_direct(3'd5, 32'h0, 32'hFFFF_FFFC, 32'h0, 5'd31);
        do_direct(3'd6, 32'h0, 32'h0000_0000, 32'h0, 5'd7);
        do_direct(3'd7, 32'h1234, 32'h40, 32'h8, 5'd9);
        do_ind(32'h0000_4000, 0, 1'b0);
        do_ind(32'h0000_8008, 3, 1'b1);

        // Stray response while idle must not produce output
        @(negedge clk);
        mem_rd_valid = 1'b1; mem_rd_data = 32'hBAD0_BAD0;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R11", "stray response ea_valid", {31'b0, ea_valid}, 32'd0);
        check("R11", "stray response busy", {31'b0, busy}, 32'd0);

        // Back-to-back accepted requests each give one pulse
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd0; req_imm = 32'hA;
        @(negedge clk);
        req_imm = 32'hB;
        check("R2", "b2b first", ea_addr, 32'hA);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "b2b second", ea_addr, 32'hB);
        check("R11", "b2b valid", {31'b0, ea_valid}, 32'd1);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [2:0] m;
            m = 3'($urandom_range(0, 7));
            if (m == 3'd4)
                do_ind($urandom, int'($urandom_range(0, 4)), 1'($urandom_range(0, 1)));
            else
                do_direct(m, $urandom, $urandom, $urandom, 5'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule